// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Agent

This block connects one peripheral interrupt request to a shared, single-wire, open-drain serialized interrupt line. All agents and the host drive and sample the line on the rising edge of the bus clock. A host opens each serial cycle with a Start pulse. The line then carries a run of three-clock IRQ/Data frames. The host closes the cycle with a Stop pulse.

The agent watches the line and tracks where each cycle begins and ends. It counts clocks from the end of the Start pulse. In the sample phase of the frame that belongs to its selected IRQ number, it reports the state of its interrupt input. The width of the Stop pulse tells the agent whether the next cycle runs in Quiet or Continuous mode. In Quiet mode, when its interrupt level has changed since the last report, the agent may pull the line low for one clock to ask the host for a new cycle.

Clock numbering: clock 0 is the first clock in which the line reads high after the Start pulse's low run. The line is sampled at each rising edge. The sample phase for IRQ n is clock 3n+2, so IRQ5 is at clock 17 and IRQ15 is at clock 47.

Top module: `sirq_agent`

## Requirements
- R1: After reset the line is released (`sirq_oe` = 0), the frame counter is idle and the mode is Continuous, so no start request is made.
- R2: When `irq_sel` holds n in 5..15 and `irq_active` is 0 at the sample point, the agent drives the line low (`sirq_oe`=1, `sirq_out`=0) during exactly clock 3n+2 of the cycle.
- R3: After driving a slot low, the agent drives the line high (`sirq_oe`=1, `sirq_out`=1) for clock 3n+3 and releases it from clock 3n+4 on.
- R4: When `irq_active` is 1 at the sample point, the agent leaves the line released for its whole slot.
- R5: When `irq_sel` is outside 5..15, the agent never drives the line in a cycle and makes no start request.
- R6: A Stop low run of exactly 2 clocks selects Quiet mode for the next cycle. A low run of 3 or more selects Continuous mode.
- R7: In Quiet mode, with the bus idle and the line high, if `irq_active` differs from the level reported in the agent's last slot (0 after reset), the agent drives the line low for exactly one clock. The earliest such clock is the second clock after the Stop pulse's first high clock. After the request the agent releases the line, and it numbers the next cycle from the end of the combined low run.
- R8: In Continuous mode the agent never makes a start request.
- R9: In Quiet mode no start request is made while `irq_active` equals the last reported level.
- R10: Single-clock low pulses inside a cycle, such as other agents' slots, do not end the cycle, and clock counting continues through them.
- R11: Outside its slot phases and its start requests the agent keeps the line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; line driven and sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_active | input | 1 | Peripheral interrupt request level, 1 = active |
| irq_sel | input | 4 | Selected IRQ number; only 5..15 are used |
| sirq_in | input | 1 | Sampled level of the shared serial interrupt line |
| sirq_oe | output | 1 | 1 when the agent drives the line |
| sirq_out | output | 1 | Level driven when `sirq_oe` is 1 |

## Verification
The slot is tried at IRQ5, IRQ7, IRQ9 and IRQ15 with the input inactive, and at IRQ15 with it active. Together these show the clock arithmetic (3n+2) separately from the polarity choice. A foreign one-clock pulse placed just before the slot shows whether the agent treats such a pulse as a Stop frame or keeps counting. Stop pulses of 2 and 3 clocks are each followed by an interrupt-level change in idle, so the mode decode is seen only through whether a start request appears and in which clock. An out-of-range selection paired with a pending level change separates the range check from the mode check.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_ACTIVE = 2'd2
  } sirq_state_e;

  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_QUIET = 1'b1
  } sirq_mode_e;

  localparam int FRAME_CLKS = 3;
  localparam int SAMPLE_OFS = 2;

  // clock index (from Start rising edge) of the sample phase for an IRQ number
  function automatic int sample_clock(input int irq_num);
    return FRAME_CLKS * irq_num + SAMPLE_OFS;
  endfunction

  function automatic logic sel_in_range(input int n, input int lo, input int hi);
    return (n >= lo) && (n <= hi);
  endfunction

endpackage

// File: rtl/sirq_frame_tracker.sv
module sirq_frame_tracker
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LR_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output sirq_state_e      state_o,
  output logic [CNT_W-1:0] cnt_o,
  output sirq_mode_e       mode_o,
  output logic             stop_end_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LR_W-1:0]  LR_MAX  = '1;
  localparam logic [LR_W-1:0]  LR_QUIET = LR_W'(2);

  sirq_state_e      state_q;
  sirq_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LR_W-1:0]  lowrun_q;

  assign stop_end_o = (state_q == ST_ACTIVE) && line_i && (lowrun_q >= LR_QUIET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_CONT;
      cnt_q    <= '0;
      lowrun_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line_i) state_q <= ST_START;
        end
        ST_START: begin
          if (line_i) begin
            state_q  <= ST_ACTIVE;
            cnt_q    <= CNT_W'(1);
            lowrun_q <= '0;
          end
        end
        ST_ACTIVE: begin
          if (stop_end_o) begin
            state_q  <= ST_IDLE;
            mode_q   <= (lowrun_q == LR_QUIET) ? MODE_QUIET : MODE_CONT;
            lowrun_q <= '0;
          end else begin
            if (line_i)                lowrun_q <= '0;
            else if (lowrun_q != LR_MAX) lowrun_q <= lowrun_q + LR_W'(1);
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;

  p_stop2_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && line_i && lowrun_q == LR_QUIET)
      |=> (mode_q == MODE_QUIET && state_q == ST_IDLE));

  p_stop3_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && line_i && lowrun_q == LR_MAX)
      |=> (mode_q == MODE_CONT && state_q == ST_IDLE));

  p_single_low_keeps_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && line_i && lowrun_q == LR_W'(1)) |=> (state_q == ST_ACTIVE));

  p_start_numbering_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && line_i) |=> (state_q == ST_ACTIVE && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
  import sirq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 4,
  parameter int IRQ_LO = 5,
  parameter int IRQ_HI = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             irq_i,
  output logic             oe_o,
  output logic             dout_o,
  output logic             rep_lvl_o,
  output logic             sel_valid_o
);

  int   next_clk;
  int   slot_clk;
  logic sample_hit;

  assign sel_valid_o = sel_in_range(int'(sel_i), IRQ_LO, IRQ_HI);

  always_comb begin
    next_clk   = int'(cnt_i) + 1;
    slot_clk   = sample_clock(int'(sel_i));
    sample_hit = active_i && sel_valid_o && (next_clk == slot_clk);
  end

  logic oe_q, dout_q, rep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b1;
      rep_q  <= 1'b0;
    end else begin
      oe_q   <= 1'b0;
      dout_q <= 1'b1;
      if (active_i) begin
        if (sample_hit) begin
          rep_q <= irq_i;
          if (!irq_i) begin
            oe_q   <= 1'b1;
            dout_q <= 1'b0;
          end
        end else if (oe_q && !dout_q) begin
          oe_q   <= 1'b1;
          dout_q <= 1'b1;
        end
      end
    end
  end

  assign oe_o      = oe_q;
  assign dout_o    = dout_q;
  assign rep_lvl_o = rep_q;

  p_line_low_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !dout_q) |-> !line_i);

  p_recovery_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !dout_q) |=> (oe_q && dout_q));

  p_release_after_recovery_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && dout_q) |=> !oe_q);

  p_low_only_when_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !dout_q) |-> !rep_q);

endmodule

// File: rtl/sirq_start_req.sv
module sirq_start_req
  import sirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  sirq_mode_e mode_i,
  input  logic       line_i,
  input  logic       irq_i,
  input  logic       rep_lvl_i,
  input  logic       sel_valid_i,
  output logic       req_oe_o
);

  logic req_fire;
  logic req_q;

  assign req_fire = idle_i && (mode_i == MODE_QUIET) && line_i && sel_valid_i
                    && (irq_i != rep_lvl_i) && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_fire;
  end

  assign req_oe_o = req_q;

  p_req_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  p_req_pulls_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !line_i);

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 4,
  parameter int IRQ_LO = 5,
  parameter int IRQ_HI = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_active,
  input  logic [SEL_W-1:0] irq_sel,
  input  logic             sirq_in,
  output logic             sirq_oe,
  output logic             sirq_out
);

  sirq_state_e      state;
  sirq_mode_e       mode;
  logic [CNT_W-1:0] frame_cnt;
  logic             stop_end;
  logic             cycle_active;
  logic             bus_idle;
  logic             slot_oe, slot_do, rep_lvl, sel_valid;
  logic             req_oe;

  sirq_frame_tracker #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (sirq_in),
    .state_o    (state),
    .cnt_o      (frame_cnt),
    .mode_o     (mode),
    .stop_end_o (stop_end)
  );

  assign cycle_active = (state == ST_ACTIVE) && !stop_end;
  assign bus_idle     = (state == ST_IDLE);

  sirq_slot_driver #(
    .CNT_W (CNT_W), .SEL_W (SEL_W), .IRQ_LO (IRQ_LO), .IRQ_HI (IRQ_HI)
  ) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (cycle_active),
    .line_i      (sirq_in),
    .cnt_i       (frame_cnt),
    .sel_i       (irq_sel),
    .irq_i       (irq_active),
    .oe_o        (slot_oe),
    .dout_o      (slot_do),
    .rep_lvl_o   (rep_lvl),
    .sel_valid_o (sel_valid)
  );

  sirq_start_req u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_i      (bus_idle),
    .mode_i      (mode),
    .line_i      (sirq_in),
    .irq_i       (irq_active),
    .rep_lvl_i   (rep_lvl),
    .sel_valid_i (sel_valid),
    .req_oe_o    (req_oe)
  );

  assign sirq_oe  = slot_oe | req_oe;
  assign sirq_out = req_oe ? 1'b0 : slot_do;

  p_req_only_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_oe |-> (mode == MODE_QUIET));

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_oe && req_oe));

  p_req_needs_valid_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_oe |-> $past(sel_valid));

endmodule

// File: tb/sirq_agent_tb.sv
module sirq_agent_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq = 1'b0;
  logic [3:0] sel = 4'd7;
  logic       host_low = 1'b0;
  logic       line;
  logic       dut_oe, dut_do;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign line = ~host_low & ~(dut_oe & ~dut_do);

  sirq_agent u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_active (irq),
    .irq_sel    (sel),
    .sirq_in    (line),
    .sirq_oe    (dut_oe),
    .sirq_out   (dut_do)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model, compared every clock
  bit line_s, irq_s, rst_s;
  int sel_s;
  int m_st = 0, m_k = 0, m_lr = 0, m_quiet = 0, m_rep = 0, m_prevlow = 0;

  always @(posedge clk) begin
    line_s <= line;
    irq_s  <= irq;
    sel_s  <= int'(sel);
    rst_s  <= rst_n;
  end

  always @(negedge clk) begin
    bit e_oe, e_do, valid, slotlow;
    string tag;
    e_oe = 0; e_do = 1; tag = "R11"; slotlow = 0;
    valid = (sel_s >= 5) && (sel_s <= 15);
    if (!rst_s) begin
      m_st = 0; m_k = 0; m_lr = 0; m_quiet = 0; m_rep = 0; tag = "R1";
    end else begin
      case (m_st)
        0: begin
          if (!line_s) m_st = 1;
          else if (m_quiet != 0 && valid && int'(irq_s) != m_rep) begin
            e_oe = 1; e_do = 0; tag = "R7";
          end
        end
        1: if (line_s) begin m_st = 2; m_k = 0; m_lr = 0; end
        default: begin
          m_k++;
          if (!line_s) m_lr = (m_lr < 3) ? m_lr + 1 : 3;
          else if (m_lr >= 2) begin m_quiet = (m_lr == 2); m_st = 0; m_lr = 0; end
          else m_lr = 0;
          if (m_st == 2) begin
            if (valid && (m_k + 1) == 3 * sel_s + 2) begin
              m_rep = int'(irq_s);
              if (!irq_s) begin e_oe = 1; e_do = 0; tag = "R2"; slotlow = 1; end
            end else if (m_prevlow != 0) begin
              e_oe = 1; e_do = 1; tag = "R3";
            end
          end
        end
      endcase
    end
    m_prevlow = slotlow;
    check((dut_oe === e_oe) && (!e_oe || dut_do === e_do), tag,
          {dut_oe, dut_do}, {e_oe, e_do});
  end

  // ---------------- directed host stimulus
  int low_idx, hi_idx, drives, req_off;

  task automatic obs(input int j);
    if (dut_oe && !dut_do && low_idx < 0) low_idx = j;
    if (dut_oe && dut_do && hi_idx < 0) hi_idx = j;
    if (dut_oe) drives++;
  endtask

  task automatic host_cycle(input int start_w, input int len, input int stop_w,
                            input int other_idx, input int flip_at);
    low_idx = -1; hi_idx = -1; drives = 0;
    repeat (start_w) begin @(negedge clk); host_low = 1'b1; end
    @(negedge clk); host_low = 1'b0;
    obs(0);
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      host_low = (j == other_idx);
      if (j == flip_at) irq = ~irq;
      obs(j);
    end
    repeat (stop_w) begin @(negedge clk); host_low = 1'b1; end
    @(negedge clk); host_low = 1'b0;
  endtask

  task automatic watch_req(input int n);
    req_off = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (dut_oe && !dut_do) begin req_off = i; break; end
    end
    if (req_off >= 0) begin
      @(negedge clk);
      check(!dut_oe, "R7 request lasts one clock", dut_oe, 0);
      host_low = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dut_oe == 1'b0, "R1 released in reset", dut_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dut_oe == 1'b0, "R1 released after reset", dut_oe, 0);
    irq = 1'b1;
    watch_req(6);
    check(req_off == -1, "R1 continuous after reset, no request", req_off, -1);
    irq = 1'b0;

    // C1: IRQ7 inactive, stop 3
    sel = 4'd7;
    host_cycle(4, 50, 3, -1, -1);
    check(low_idx == 23, "R2 IRQ7 sample clock", low_idx, 23);
    check(hi_idx == 24, "R3 IRQ7 recovery clock", hi_idx, 24);
    check(drives == 2, "R11 IRQ7 drive clocks", drives, 2);

    // C2: IRQ5 with foreign pulse at clock 14, stop 2 -> quiet
    sel = 4'd5;
    host_cycle(4, 50, 2, 14, -1);
    check(low_idx == 17, "R10 IRQ5 slot after foreign pulse", low_idx, 17);
    check(hi_idx == 18, "R3 IRQ5 recovery clock", hi_idx, 18);
    watch_req(6);
    check(req_off == -1, "R9 quiet, same level, no request", req_off, -1);

    // C3: IRQ15, level flips after slot, stop 2 -> quiet request
    sel = 4'd15;
    host_cycle(4, 50, 2, -1, 49);
    check(low_idx == 47, "R2 IRQ15 sample clock", low_idx, 47);
    watch_req(6);
    check(req_off == 2, "R7 request in second clock after stop rise", req_off, 2);
    check(req_off == 2, "R6 two-clock stop gives quiet", req_off, 2);

    // C4: serviced cycle with irq active, stop 3 -> continuous
    host_cycle(3, 50, 3, -1, -1);
    check(drives == 0, "R4 active irq leaves slot released", drives, 0);
    irq = 1'b0;
    watch_req(6);
    check(req_off == -1, "R8 continuous, no request", req_off, -1);

    // C6: out-of-range selection, stop 2 -> quiet, level differs
    sel = 4'd3;
    host_cycle(4, 50, 2, -1, -1);
    check(drives == 0, "R5 selection 3 never drives", drives, 0);
    watch_req(6);
    check(req_off == -1, "R5 selection 3 makes no request", req_off, -1);

    // C7: selection back in range -> quiet request, then counted cycle
    sel = 4'd9;
    watch_req(4);
    check(req_off > 0, "R7 request after level differs", req_off, 1);
    host_cycle(3, 50, 3, -1, -1);
    check(low_idx == 29, "R7 numbering from end of combined start", low_idx, 29);
    check(hi_idx == 30, "R3 IRQ9 recovery clock", hi_idx, 30);

    // C8: three-clock stop -> continuous, level change gives no request
    irq = 1'b1;
    watch_req(6);
    check(req_off == -1, "R6 three-clock stop gives continuous", req_off, -1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule